// File: doc/BRIEF.md
# Background Tile Fetch Sequencer

This block drives the background half of a tile-based raster video generator. A dot counter and a line counter walk through a frame that ends with a pre-render line. On every dot of a rendering line the block decides whether video memory is read, which address is placed on the bus, and what happens to the pixel pipeline. Each eight-dot tile slot holds four two-dot reads. The tile index comes first, then the attribute byte, then the low pattern plane and last the high pattern plane. The fetched bytes are staged in latches and loaded into 16-bit shift registers, and these produce one background pixel per dot.

The current scroll address is held outside the block and arrives on `cur_addr`. The block tells its owner when to move that address: a coarse horizontal step after each tile, a vertical step at the end of the visible fetches, a horizontal reload after them, and a vertical reload on a window of the pre-render line. The first two tiles of each line are fetched near the end of the line before. A 3-bit fine scroll value picks the tap of the shift registers, so the picture can start part-way into a tile.

The scroll address uses this layout: bits 14..12 fine row, bits 11..10 table select, bits 9..5 coarse row, bits 4..0 coarse column.

Top module: `bg_fetch_seq`

## Requirements
- R1: After reset the block sits at dot 0 of the pre-render line (line `LINES_TOTAL-1`) with every output low. Dots count from 0 to 340, and then the line advances. Lines 0 to `LINES_VISIBLE-1` are visible, and the line after the pre-render line is line 0.
- R2: On dots 1-256 and 321-336 of a rendering line (visible or pre-render), the slot phase is dot mod 8. Phases 1-2 read address `0x2000 | cur_addr[11:0]`. Phases 3-4 read `0x23C0 | cur_addr[11:10]<<10 | cur_addr[9:7]<<3 | cur_addr[4:2]`. Phases 5-6 read `{0, pat_sel, tile, 0, cur_addr[14:12]}`, where tile is the byte returned at phase 2. Phases 7 and 0 read the high plane. Each address holds for both dots of its pair, and `mem_rd` is high on the second dot only, when `mem_data` is taken.
- R3: The high pattern plane address is the low plane address plus 8.
- R4: No read is issued on dot 0, on dots 257-320, or on lines that do not render, and `mem_addr` is zero whenever `mem_rd` is not part of a fetch pair.
- R5: Dots 337-340 of a rendering line issue two name-table reads. The data returned then never changes a pixel.
- R6: On a visible line, `pix_valid` is high on dots 2-257 and shows pixel x = dot-2. `pix_out` is {attribute bit 1, attribute bit 0, high plane bit, low plane bit}. The line's tile stream starts with the two tiles fetched on dots 321-336 of the previous line.
- R7: With fine scroll f, pixel x shows stream pixel x+f. This reaches into a 33rd tile, and bit 7 of each pattern byte is the leftmost pixel. The attribute pair is taken from the attribute byte shifted right by {coarse_row[1], coarse_col[1], 0}.
- R8: On rendering lines, `inc_x` pulses on dots 8, 16, …, 256, 328 and 336, `inc_y` pulses on dot 256, and `copy_h` pulses on dot 257.
- R9: `copy_v` is high on every dot from 280 to 304 of the pre-render line and on no other dot.
- R10: While `render_en` is low there are no reads, `mem_addr` is zero, every strobe is low, `pix_valid` is low and `pix_out` is zero. The counters keep running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| render_en | input | 1 | Background rendering enable |
| pat_sel | input | 1 | Pattern table half select |
| fine_x | input | 3 | Fine horizontal scroll |
| cur_addr | input | 15 | Current scroll address from the external register |
| mem_addr | output | 14 | Video memory address |
| mem_rd | output | 1 | Read strobe, second dot of a fetch pair |
| mem_data | input | 8 | Video memory read data |
| inc_x | output | 1 | Coarse horizontal step request |
| inc_y | output | 1 | Vertical step request |
| copy_h | output | 1 | Horizontal scroll reload request |
| copy_v | output | 1 | Vertical scroll reload request |
| pix_valid | output | 1 | Background pixel valid |
| pix_out | output | 4 | Attribute pair and pattern pair of the pixel |

## Verification
Two cases are hard to reach from the ports. The first is the seam where a line's leading pixels come from the previous line's prefetch. The second is the far edge, where a fine scroll of 7 reads into a tile fetched after the last visible one. The bench models the external scroll register from the strobes it expects and returns data that is a hash of the address. It runs whole frames of a four-line configuration once for each fine scroll value, so every pixel of both seams is compared. During dots 337-340 the memory model returns inverted data, so any use of the dummy reads shows up as wrong pixels. One frame with rendering off sits between two enabled frames, which shows that the pipeline refills from the pre-render line.

// File: rtl/bg_fetch_pkg.sv
package bg_fetch_pkg;
   localparam int DOT_W  = 9;
   localparam int ADDR_W = 14;
   localparam int BYTE_W = 8;
   localparam int PIX_W  = 4;
   localparam int VADR_W = 15;

   typedef logic [DOT_W-1:0] dot_t;

   localparam dot_t DOT_LAST        = 9'd340;
   localparam dot_t DOT_FETCH_LAST  = 9'd256;
   localparam dot_t DOT_HCOPY       = 9'd257;
   localparam dot_t DOT_GAP_LAST    = 9'd320;
   localparam dot_t DOT_PRE_FIRST   = 9'd321;
   localparam dot_t DOT_PRE_LAST    = 9'd336;
   localparam dot_t DOT_DUMMY_FIRST = 9'd337;
   localparam dot_t DOT_VCOPY_FIRST = 9'd280;
   localparam dot_t DOT_VCOPY_LAST  = 9'd304;
   localparam dot_t DOT_SHA_FIRST   = 9'd2;
   localparam dot_t DOT_SHA_LAST    = 9'd257;
   localparam dot_t DOT_SHB_FIRST   = 9'd322;
   localparam dot_t DOT_SHB_LAST    = 9'd337;

   typedef enum logic [1:0] {
      FK_NAME = 2'd0,
      FK_ATTR = 2'd1,
      FK_PLO  = 2'd2,
      FK_PHI  = 2'd3
   } fetch_kind_e;

   // phases 1,2 -> name; 3,4 -> attr; 5,6 -> low; 7,0 -> high
   function automatic fetch_kind_e kind_of(input dot_t d);
      logic [2:0] q;
      q = d[2:0] - 3'd1;
      return fetch_kind_e'(q[2:1]);
   endfunction
endpackage

// File: rtl/bg_dot_timer.sv
module bg_dot_timer
   import bg_fetch_pkg::*;
#(
   parameter int LINES_VISIBLE = 240,
   parameter int LINES_TOTAL   = 262,
   localparam int LINE_W       = $clog2(LINES_TOTAL)
) (
   input  logic              clk,
   input  logic              rst_n,
   output dot_t              dot,
   output logic [LINE_W-1:0] line,
   output logic              vis_line,
   output logic              pre_line
);
   localparam logic [LINE_W-1:0] PRE_IDX  = LINE_W'(LINES_TOTAL - 1);
   localparam logic [LINE_W-1:0] LAST_VIS = LINE_W'(LINES_VISIBLE - 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dot  <= '0;
         line <= PRE_IDX;
      end else if (dot == DOT_LAST) begin
         dot  <= '0;
         line <= (line == PRE_IDX) ? '0 : line + 1'b1;
      end else begin
         dot <= dot + 1'b1;
      end
   end

   assign vis_line = (line <= LAST_VIS);
   assign pre_line = (line == PRE_IDX);
endmodule

// File: rtl/bg_fetch_ctrl.sv
module bg_fetch_ctrl
   import bg_fetch_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              render_en,
   input  dot_t              dot,
   input  logic              render_line,
   input  logic              pre_line,
   input  logic [VADR_W-1:0] cur_addr,
   input  logic              pat_sel,
   input  logic [BYTE_W-1:0] mem_data,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              inc_x,
   output logic              inc_y,
   output logic              copy_h,
   output logic              copy_v,
   output logic              shift_en,
   output logic              reload,
   output logic [BYTE_W-1:0] lat_lo,
   output logic [BYTE_W-1:0] lat_hi,
   output logic [1:0]        lat_attr
);
   logic              active, in_main, in_pre, in_dummy, real_fetch, any_fetch;
   fetch_kind_e       kind;
   logic [BYTE_W-1:0] tile_q;
   logic [ADDR_W-1:0] addr_sel, plo_addr;
   logic [BYTE_W-1:0] attr_sh;

   always_comb begin
      active     = render_en && render_line;
      in_main    = (dot >= 9'd1) && (dot <= DOT_FETCH_LAST);
      in_pre     = (dot >= DOT_PRE_FIRST) && (dot <= DOT_PRE_LAST);
      in_dummy   = (dot >= DOT_DUMMY_FIRST);
      real_fetch = active && (in_main || in_pre);
      any_fetch  = real_fetch || (active && in_dummy);
      kind       = in_dummy ? FK_NAME : kind_of(dot);
      plo_addr   = {1'b0, pat_sel, tile_q, 1'b0, cur_addr[14:12]};
      unique case (kind)
         FK_NAME: addr_sel = {2'b10, cur_addr[11:0]};
         FK_ATTR: addr_sel = {2'b10, cur_addr[11:10], 4'b1111, cur_addr[9:7], cur_addr[4:2]};
         FK_PLO:  addr_sel = plo_addr;
         FK_PHI:  addr_sel = plo_addr + ADDR_W'(8);
      endcase
      mem_addr = any_fetch ? addr_sel : '0;
      mem_rd   = any_fetch && !dot[0];
      attr_sh  = mem_data >> {cur_addr[6], cur_addr[1], 1'b0};

      inc_x  = real_fetch && (dot[2:0] == 3'd0);
      inc_y  = active && (dot == DOT_FETCH_LAST);
      copy_h = active && (dot == DOT_HCOPY);
      copy_v = render_en && pre_line && (dot >= DOT_VCOPY_FIRST) && (dot <= DOT_VCOPY_LAST);

      shift_en = active && (((dot >= DOT_SHA_FIRST) && (dot <= DOT_SHA_LAST)) ||
                            ((dot >= DOT_SHB_FIRST) && (dot <= DOT_SHB_LAST)));
      reload   = shift_en && (dot[2:0] == 3'd1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tile_q   <= '0;
         lat_lo   <= '0;
         lat_hi   <= '0;
         lat_attr <= '0;
      end else if (real_fetch && !dot[0]) begin
         unique case (kind)
            FK_NAME: tile_q   <= mem_data;
            FK_ATTR: lat_attr <= attr_sh[1:0];
            FK_PLO:  lat_lo   <= mem_data;
            FK_PHI:  lat_hi   <= mem_data;
         endcase
      end
   end
endmodule

// File: rtl/bg_pixel_shift.sv
module bg_pixel_shift
   import bg_fetch_pkg::*;
#(
   parameter int PLANE_W = 8,
   localparam int FX_W   = $clog2(PLANE_W)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               shift_en,
   input  logic               reload,
   input  logic [PLANE_W-1:0] lat_lo,
   input  logic [PLANE_W-1:0] lat_hi,
   input  logic [1:0]         lat_attr,
   input  logic [FX_W-1:0]    fine_x,
   input  logic               pix_en,
   output logic [PIX_W-1:0]   pix
);
   localparam int SH_W  = 2 * PLANE_W;
   localparam int TAP_W = $clog2(SH_W);

   logic [TAP_W-1:0]   tap;
   logic [PLANE_W-1:0] load_val [PIX_W];

   assign tap = TAP_W'(SH_W - 1) - TAP_W'(fine_x);

   always_comb begin
      load_val[0] = lat_lo;
      load_val[1] = lat_hi;
      load_val[2] = {PLANE_W{lat_attr[0]}};
      load_val[3] = {PLANE_W{lat_attr[1]}};
   end

   for (genvar g = 0; g < PIX_W; g++) begin : g_plane
      logic [SH_W-1:0] sh;
      always_ff @(posedge clk) begin
         if (!rst_n)
            sh <= '0;
         else if (shift_en)
            sh <= reload ? {sh[SH_W-2:PLANE_W-1], load_val[g]} : {sh[SH_W-2:0], 1'b0};
      end
      assign pix[g] = pix_en & sh[tap];
   end
endmodule

// File: rtl/bg_fetch_seq.sv
module bg_fetch_seq
   import bg_fetch_pkg::*;
#(
   parameter int LINES_VISIBLE = 240,
   parameter int LINES_TOTAL   = 262
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                render_en,
   input  logic                pat_sel,
   input  logic [2:0]          fine_x,
   input  logic [VADR_W-1:0]   cur_addr,
   output logic [ADDR_W-1:0]   mem_addr,
   output logic                mem_rd,
   input  logic [BYTE_W-1:0]   mem_data,
   output logic                inc_x,
   output logic                inc_y,
   output logic                copy_h,
   output logic                copy_v,
   output logic                pix_valid,
   output logic [PIX_W-1:0]    pix_out
);
   localparam int LINE_W = $clog2(LINES_TOTAL);

   if (LINES_VISIBLE < 1 || LINES_TOTAL <= LINES_VISIBLE) begin : g_bad_lines
      $error("bg_fetch_seq: LINES_TOTAL must exceed LINES_VISIBLE >= 1");
   end

   dot_t              dot_w;
   logic [LINE_W-1:0] line_w;
   logic              vis_line, pre_line, shift_en, reload;
   logic [BYTE_W-1:0] lat_lo, lat_hi;
   logic [1:0]        lat_attr;

   bg_dot_timer #(.LINES_VISIBLE(LINES_VISIBLE), .LINES_TOTAL(LINES_TOTAL)) u_tmr (
      .clk(clk), .rst_n(rst_n), .dot(dot_w), .line(line_w),
      .vis_line(vis_line), .pre_line(pre_line)
   );

   bg_fetch_ctrl u_ctl (
      .clk(clk), .rst_n(rst_n), .render_en(render_en), .dot(dot_w),
      .render_line(vis_line || pre_line), .pre_line(pre_line),
      .cur_addr(cur_addr), .pat_sel(pat_sel), .mem_data(mem_data),
      .mem_addr(mem_addr), .mem_rd(mem_rd), .inc_x(inc_x), .inc_y(inc_y),
      .copy_h(copy_h), .copy_v(copy_v), .shift_en(shift_en), .reload(reload),
      .lat_lo(lat_lo), .lat_hi(lat_hi), .lat_attr(lat_attr)
   );

   assign pix_valid = render_en && vis_line && (dot_w >= DOT_SHA_FIRST) && (dot_w <= DOT_SHA_LAST);

   bg_pixel_shift #(.PLANE_W(BYTE_W)) u_shf (
      .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .reload(reload),
      .lat_lo(lat_lo), .lat_hi(lat_hi), .lat_attr(lat_attr),
      .fine_x(fine_x), .pix_en(pix_valid), .pix(pix_out)
   );
endmodule

// File: rtl/bg_fetch_seq_chk.sv
module bg_fetch_seq_chk
   import bg_fetch_pkg::*;
#(
   parameter int LINES_TOTAL = 262,
   localparam int LINE_W     = $clog2(LINES_TOTAL)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              render_en,
   input logic              mem_rd,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              inc_x,
   input logic              copy_h,
   input logic              copy_v,
   input logic              pix_valid,
   input dot_t              dot,
   input logic [LINE_W-1:0] line
);
   localparam logic [LINE_W-1:0] PRE_IDX = LINE_W'(LINES_TOTAL - 1);

   AST_DOT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (dot == DOT_LAST) |=> (dot == '0)); // R1
   AST_READ_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |=> !mem_rd); // R2
   AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd && $past(render_en)) |-> $stable(mem_addr)); // R2
   AST_HI_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mem_rd) && render_en && dot[2:0] == 3'd7 && dot < DOT_DUMMY_FIRST)
      |-> (mem_addr == $past(mem_addr) + ADDR_W'(8))); // R3
   AST_NO_READ_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (dot > DOT_FETCH_LAST && dot <= DOT_GAP_LAST) |-> !mem_rd); // R4
   AST_PIX_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid |-> (dot >= DOT_SHA_FIRST && dot <= DOT_SHA_LAST)); // R6
   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({inc_x, copy_h, copy_v})); // R8
   AST_VCOPY_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      copy_v |-> (line == PRE_IDX && dot >= DOT_VCOPY_FIRST && dot <= DOT_VCOPY_LAST)); // R9
   AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !render_en |-> (!mem_rd && mem_addr == '0 && !pix_valid)); // R10
endmodule

bind bg_fetch_seq bg_fetch_seq_chk #(.LINES_TOTAL(LINES_TOTAL)) u_chk (
   .clk(clk), .rst_n(rst_n), .render_en(render_en), .mem_rd(mem_rd),
   .mem_addr(mem_addr), .inc_x(inc_x), .copy_h(copy_h), .copy_v(copy_v),
   .pix_valid(pix_valid), .dot(dot_w), .line(line_w)
);

// File: tb/bg_fetch_seq_tb_top.sv
module bg_fetch_seq_tb_top;
   localparam int VIS = 2, TOT = 4, PRE = 3, DOTS = 341;
   localparam logic [2:0] FY  = 3'd5;
   localparam logic [1:0] NTS = 2'd1;
   localparam logic [4:0] CY  = 5'd14;
   localparam logic       SEL = 1'b1;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic        rst_n, render_en;
   logic [2:0]  fine_x;
   logic [4:0]  bx;
   logic [14:0] cur_addr;
   logic [13:0] mem_addr;
   logic        mem_rd, inc_x, inc_y, copy_h, copy_v, pix_valid;
   logic [7:0]  mem_data;
   logic [3:0]  pix_out;
   int bd, bl, n_chk, n_fail;
   bit done;

   function automatic logic [7:0] mv(input logic [13:0] a);
      logic [7:0] m;
      m = a[7:0] * 8'd37;
      return m ^ {a[13:8], a[1:0]} ^ 8'hA5;
   endfunction

   assign cur_addr = {FY, NTS, CY, bx};
   assign mem_data = (bd >= 337) ? ~mv(mem_addr) : mv(mem_addr);

   bg_fetch_seq #(.LINES_VISIBLE(VIS), .LINES_TOTAL(TOT)) dut_i (
      .clk(clk), .rst_n(rst_n), .render_en(render_en), .pat_sel(SEL),
      .fine_x(fine_x), .cur_addr(cur_addr), .mem_addr(mem_addr), .mem_rd(mem_rd),
      .mem_data(mem_data), .inc_x(inc_x), .inc_y(inc_y), .copy_h(copy_h),
      .copy_v(copy_v), .pix_valid(pix_valid), .pix_out(pix_out)
   );

   function automatic logic [13:0] nt_a(input logic [4:0] cx);
      return {2'b10, NTS, CY, cx};
   endfunction
   function automatic logic [13:0] at_a(input logic [4:0] cx);
      return {2'b10, NTS, 4'b1111, CY[4:2], cx[4:2]};
   endfunction
   function automatic logic [13:0] pl_a(input logic [4:0] cx);
      return {1'b0, SEL, mv(nt_a(cx)), 1'b0, FY};
   endfunction
   function automatic logic [3:0] exp_pix(input int x, input int fx);
      int p, b;
      logic [4:0] cx;
      logic [7:0] lo, hi, a;
      p  = x + fx;
      b  = p % 8;
      cx = 5'((p / 8) % 32);
      lo = mv(pl_a(cx));
      hi = mv(pl_a(cx) | 14'd8);
      a  = mv(at_a(cx)) >> {CY[1], cx[1], 1'b0};
      return {a[1], a[0], hi[7-b], lo[7-b]};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s line %0d dot %0d: actual %h expected %h", req, bl, bd, act, exp);
      end
   endtask

   task automatic check_dot(input bit en, input int fx);
      bit render, act_l, fetch, dummy, ev;
      int ph, kind;
      logic [13:0] ea;
      logic [3:0] es;
      string tg;
      render = (bl < VIS) || (bl == PRE);
      act_l  = en && render;
      fetch  = act_l && ((bd >= 1 && bd <= 256) || bd >= 321);
      dummy  = act_l && bd >= 337;
      ph     = bd % 8;
      kind   = dummy ? 0 : ((ph + 7) % 8) / 2;
      case (kind)
         0: ea = nt_a(bx);
         1: ea = at_a(bx);
         2: ea = pl_a(bx);
         default: ea = pl_a(bx) | 14'd8;
      endcase
      if (!fetch) ea = '0;
      if (bd == 0 && bl == 0) tg = "R1";
      else if (!en) tg = "R10";
      else if (dummy) tg = "R5";
      else if (fetch && kind == 3) tg = "R3";
      else if (fetch) tg = "R2";
      else tg = "R4";
      chk(tg, {17'd0, mem_rd, mem_addr}, {17'd0, fetch && (bd % 2 == 0), ea});
      // strobes: R8 steps and horizontal reload, R9 vertical reload window
      es[3] = fetch && !dummy && ph == 0;
      es[2] = act_l && bd == 256;
      es[1] = act_l && bd == 257;
      es[0] = en && bl == PRE && bd >= 280 && bd <= 304;
      tg = !en ? "R10" : (bl == PRE && bd >= 280 && bd <= 304) ? "R9" : "R8";
      chk(tg, {28'd0, inc_x, inc_y, copy_h, copy_v}, {28'd0, es});
      ev = en && bl < VIS && bd >= 2 && bd <= 257;
      tg = !en ? "R10" : (fx != 0) ? "R7" : "R6";
      chk(tg, {27'd0, pix_valid, pix_out}, {27'd0, ev, ev ? exp_pix(bd - 2, fx) : 4'd0});
      if (es[1]) bx = '0;
      else if (es[3]) bx = bx + 5'd1;
   endtask

   task automatic run_frame(input bit en, input int fx);
      for (int i = 0; i < TOT * DOTS; i++) begin
         render_en = en;
         fine_x    = 3'(fx);
         #1;
         check_dot(en, fx);
         @(negedge clk);
         bd++;
         if (bd == DOTS) begin
            bd = 0;
            bl = (bl == PRE) ? 0 : bl + 1;
         end
      end
   endtask

   initial begin
      n_chk = 0; n_fail = 0; done = 1'b0;
      rst_n = 1'b0; render_en = 1'b1; fine_x = 3'd0; bx = '0;
      bd = 0; bl = PRE;
      repeat (3) @(negedge clk);
      #1;
      // R1: reset state, all outputs idle at dot 0 of the pre-render line
      chk("R1", {10'd0, mem_rd, mem_addr, inc_x, inc_y, copy_h, copy_v, pix_valid, pix_out}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      for (int f = 0; f < 8; f++) run_frame(1'b1, f);
      run_frame(1'b0, 2);
      run_frame(1'b1, 5);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end
endmodule